// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block collects up to 64 interrupt sources and presents one processor interrupt line together with the index of the source currently being served. Every source owns one control byte that holds an enable flag and a two-bit trigger selection: active-high level, rising edge or falling edge. Edge-triggered sources set a sticky status bit. Software clears that bit by writing a one to it. Level-triggered sources are pending for as long as their input stays high.

Software reaches the block through a simple word-wide register port. The port has a write strobe, per-byte write enables, a read strobe and registered read data. A global control word picks the arbitration scheme. With rotation off, the lowest-numbered enabled pending source wins. With rotation on, the search for the next winner starts at the source just above the one granted last. The winner is registered once per clock into the interrupt output and the index output.

Top module: `irq_rotor_top`

## Requirements
- R1: After reset every control byte, both status words and the global control word read 0, and the interrupt output is low.
- R2: The control byte for source n sits at byte offset 0x40+n (word 0x40+4*(n/4), byte lane n%4). Bit 3 is the enable and bits 5:4 are the trigger mode. All other bits read 0. Only lanes whose write-enable is set are updated.
- R3: A source in mode 0 (level) that is enabled and whose input is high raises the interrupt output and the matching index one clock after the input rises. A disabled source never raises the output.
- R4: In mode 1 (rising edge), a 0-to-1 change of the input sets the source's status bit on the next clock, but only while the source is enabled. The interrupt output follows one clock later.
- R5: In mode 2 (falling edge), a 1-to-0 change of the input latches the status bit in the same way as R4.
- R6: Status bits live at 0x80 (sources 0-31, bit n) and 0x84 (sources 32-63, bit n-32). Writing 1 clears a latched edge bit and writing 0 leaves it unchanged. For a level source, the bit shows the live input and write-1 has no effect.
- R7: While global control bit 6 (word 0x20) is 0, the lowest-numbered pending source is granted on every cycle.
- R8: While global control bit 6 is 1, each new search begins at the index just above the last granted source and wraps, so pending sources are served in turn.
- R9: When no source is pending, the interrupt output is low on the next clock and the index output keeps its last value.
- R10: Read data appears on the clock after the read strobe. Unmapped or misaligned offsets, including 0x24, read 0. Word 0x20 reads back only bit 6.
- R11: Trigger mode 3 is reserved, and a source set to it never becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Processor interrupt request |
| irq_src_o | output | 6 | Index of the granted source |

## Verification
Each source is swept on its own through level, rising-edge and falling-edge modes. This separates the one-clock latency of the level path from the two-clock latency of the latched edge path, and it exposes any index that is miswired in the decode, the status word or the encoder. Disabled, reserved-mode and write-zero stimuli check that nothing latches without cause. The level source has its own write-1 stimulus, which tells the live-input status apart from the sticky status. Three level sources held high together compare a constant winner under fixed priority with a strict cyclic order under rotation.

// File: rtl/irq_rotor_pkg.sv
package irq_rotor_pkg;
  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_RSVD  = 2'd3
  } trig_e;

  localparam int EN_BIT   = 3;
  localparam int MODE_LSB = 4;
  localparam int ROT_BIT  = 6;

  localparam int GCTL_WORD      = 8;   // byte 0x20
  localparam int CTRL_BASE_WORD = 16;  // byte 0x40
  localparam int STAT_BASE_WORD = 32;  // byte 0x80

  function automatic logic [7:0] pack_ctrl(input logic en, input trig_e mode);
    logic [7:0] b;
    b = '0;
    b[EN_BIT] = en;
    b[MODE_LSB +: 2] = mode;
    return b;
  endfunction
endpackage

// File: rtl/irq_rotor_rst_sync.sv
module irq_rotor_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/irq_rotor_src_cell.sv
module irq_rotor_src_cell
  import irq_rotor_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wbyte,
  input  logic       stat_clr,
  output logic       en_o,
  output trig_e      mode_o,
  output logic       pend_o,
  output logic       stat_o
);
  logic  en_q, en_d;
  trig_e mode_q, mode_d;
  logic  prev_q;
  logic  stat_q, stat_d;
  logic  edge_hit;
  logic  is_edge;

  // next-state
  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    if (ctrl_we) begin
      en_d   = ctrl_wbyte[EN_BIT];
      mode_d = trig_e'(ctrl_wbyte[MODE_LSB +: 2]);
    end
  end

  always_comb begin
    is_edge  = (mode_q == TRIG_RISE) || (mode_q == TRIG_FALL);
    edge_hit = ((mode_q == TRIG_RISE) &&  src_i && !prev_q) ||
               ((mode_q == TRIG_FALL) && !src_i &&  prev_q);
    stat_d = stat_q;
    if (stat_clr) stat_d = 1'b0;
    if (en_q && edge_hit) stat_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= TRIG_LEVEL;
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      prev_q <= src_i;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (mode_q)
      TRIG_LEVEL: pend_o = en_q && src_i;
      TRIG_RISE,
      TRIG_FALL:  pend_o = en_q && stat_q;
      default:    pend_o = 1'b0;
    endcase
    stat_o = (mode_q == TRIG_LEVEL) ? src_i : stat_q;
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;

  // R4/R5: an enabled selected edge always leaves the status bit set
  a_r4_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && edge_hit) |=> stat_q);
  // R4: the status bit only rises for an enabled edge source
  a_r4_latch_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> ($past(en_q) && $past(is_edge)));
  // R6: write-1 clear without a new edge empties the bit
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !(en_q && edge_hit)) |=> !stat_q);
  // R11: reserved mode never pends
  a_r11_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_RSVD) |-> !pend_o);
endmodule

// File: rtl/irq_rotor_arbiter.sv
module irq_rotor_arbiter #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               rot_en_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic             irq_q, irq_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] start;
  logic             found;
  logic [IDX_W-1:0] win;

  // search from start upward with wrap; first hit wins
  always_comb begin
    start = rot_en_i ? idx_q + 1'b1 : '0;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      logic [IDX_W-1:0] cand;
      cand = start + IDX_W'(i);
      if (!found && pend_i[cand]) begin
        found = 1'b1;
        win   = cand;
      end
    end
  end

  always_comb begin
    irq_d = found;
    idx_d = found ? win : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= irq_d;
      idx_q <= idx_d;
    end
  end

  assign irq_o = irq_q;
  assign idx_o = idx_q;

  // R3: any pending source raises the request on the next clock
  a_r3_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_i) |=> irq_q);
  // R9: idle drops the request and holds the index
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend_i) |=> (!irq_q && $stable(idx_q)));
  // R7: fixed priority picks source 0 when it pends
  a_r7_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_en_i && pend_i[0]) |=> (idx_q == '0));
  // R8: with rotation and a competitor, the same source is not granted twice in a row
  a_r8_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_en_i && irq_q && ($countones(pend_i) > 1)) |=> (idx_q != $past(idx_q)));
endmodule

// File: rtl/irq_rotor_top.sv
module irq_rotor_top
  import irq_rotor_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int WORD_W = ADDR_W - 2,
  localparam int LANES  = DATA_W / 8,
  localparam int CTRL_WORDS = NUM_SRC / LANES,
  localparam int STAT_WORDS = (NUM_SRC + DATA_W - 1) / DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [LANES-1:0]   reg_wstrb,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_src_o
);
  logic              rst_ns;
  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              rot_q, rot_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [NUM_SRC-1:0] en_v, pend_v, stat_v;
  trig_e              mode_v [NUM_SRC];

  irq_rotor_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign word    = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  // global control word
  always_comb begin
    rot_d = rot_q;
    if (reg_wr && aligned && (int'(word) == GCTL_WORD) && reg_wstrb[0])
      rot_d = reg_wdata[ROT_BIT];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rot_q <= 1'b0;
    else         rot_q <= rot_d;
  end

  // per-source cells
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int LANE  = n % LANES;
    localparam int CWORD = CTRL_BASE_WORD + n / LANES;
    localparam int SWORD = STAT_BASE_WORD + n / DATA_W;
    localparam int SBIT  = n % DATA_W;
    logic ctrl_we, stat_clr;

    assign ctrl_we  = reg_wr && aligned && (int'(word) == CWORD) && reg_wstrb[LANE];
    assign stat_clr = reg_wr && aligned && (int'(word) == SWORD) && reg_wdata[SBIT];

    irq_rotor_src_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_ns),
      .src_i      (src_i[n]),
      .ctrl_we    (ctrl_we),
      .ctrl_wbyte (reg_wdata[8*LANE +: 8]),
      .stat_clr   (stat_clr),
      .en_o       (en_v[n]),
      .mode_o     (mode_v[n]),
      .pend_o     (pend_v[n]),
      .stat_o     (stat_v[n])
    );
  end

  irq_rotor_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_ns),
    .pend_i   (pend_v),
    .rot_en_i (rot_q),
    .irq_o    (irq_o),
    .idx_o    (irq_src_o)
  );

  // read mux
  always_comb begin
    rdata_d = '0;
    if (aligned) begin
      if (int'(word) == GCTL_WORD) rdata_d[ROT_BIT] = rot_q;
      for (int w = 0; w < CTRL_WORDS; w++) begin
        if (int'(word) == CTRL_BASE_WORD + w) begin
          for (int l = 0; l < LANES; l++)
            rdata_d[8*l +: 8] = pack_ctrl(en_v[w*LANES+l], mode_v[w*LANES+l]);
        end
      end
      for (int s = 0; s < STAT_WORDS; s++) begin
        if (int'(word) == STAT_BASE_WORD + s) begin
          for (int b = 0; b < DATA_W; b++)
            if (s*DATA_W + b < NUM_SRC) rdata_d[b] = stat_v[s*DATA_W + b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  // R10: a misaligned read returns zero on the next clock
  a_r10_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_rd && !aligned) |=> (reg_rdata == '0));
  // R10: read data only changes after a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/irq_rotor_top_test.sv
module irq_rotor_top_test;
  logic        clk;
  logic        rst_n;
  logic [63:0] src;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic [31:0] rdata;
  logic        irq;
  logic [5:0]  idx;

  int tests, fails, cycles;
  bit done;

  irq_rotor_top uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_wstrb(wstrb),
    .reg_rdata(rdata), .irq_o(irq), .irq_src_o(idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    addr = a; wdata = d; wstrb = s; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic set_ctrl(input int n, input logic [7:0] b);
    reg_write(8'(8'h40 + (n & ~3)), 32'(b) << (8 * (n % 4)), 4'(1 << (n % 4)));
  endtask

  function automatic int next_of(input int prev);
    if (prev < 3)  return 3;
    if (prev < 10) return 10;
    if (prev < 40) return 40;
    return 3;
  endfunction

  initial begin
    logic [31:0] d;
    tests = 0; fails = 0; cycles = 0; done = 1'b0;
    src = '0; wr = 0; rd = 0; addr = '0; wdata = '0; wstrb = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    for (int w = 0; w < 16; w++) begin
      reg_read(8'(8'h40 + 4*w), d);
      chk("R1 ctrl", d, 0);
    end
    reg_read(8'h80, d); chk("R1 stat0", d, 0);
    reg_read(8'h84, d); chk("R1 stat1", d, 0);
    reg_read(8'h20, d); chk("R1 gctl", d, 0);

    // R2: field layout and byte lanes
    reg_write(8'h44, 32'hFFFF_FFFF, 4'hF);
    reg_read(8'h44, d); chk("R2 mask", d, 32'h3838_3838);
    reg_write(8'h44, 32'h0000_0000, 4'h2);
    reg_read(8'h44, d); chk("R2 lane", d, 32'h3838_0038);
    reg_write(8'h44, 32'h0, 4'hF);
    reg_read(8'h44, d); chk("R2 clear", d, 0);

    // R10: read map details
    reg_write(8'h20, 32'hFFFF_FFFF, 4'hF);
    reg_read(8'h20, d); chk("R10 gctl bit6", d, 32'h40);
    reg_write(8'h20, 32'h0, 4'hF);
    reg_read(8'h24, d); chk("R10 0x24", d, 0);
    reg_read(8'h10, d); chk("R10 unmapped", d, 0);
    reg_write(8'h40, 32'h0808_0808, 4'hF);
    reg_read(8'h41, d); chk("R10 misaligned", d, 0);
    reg_read(8'h40, d); chk("R10 latency", d, 32'h0808_0808);
    reg_write(8'h40, 32'h0, 4'hF);

    // R3/R9/R6: level sweep
    for (int i = 0; i < 64; i++) begin
      set_ctrl(i, 8'h08);
      src[i] = 1'b1;
      @(negedge clk);
      chk("R3 level irq", 32'(irq), 1);
      chk("R3 level idx", 32'(idx), 32'(i));
      reg_write(i < 32 ? 8'h80 : 8'h84, 32'(1) << (i % 32), 4'hF);
      reg_read(i < 32 ? 8'h80 : 8'h84, d);
      chk("R6 level live", d, 32'(1) << (i % 32));
      src[i] = 1'b0;
      @(negedge clk);
      chk("R9 idle irq", 32'(irq), 0);
      chk("R9 idx hold", 32'(idx), 32'(i));
      set_ctrl(i, 8'h00);
    end

    // R3: disabled level source
    src[17] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 disabled", 32'(irq), 0);
    src[17] = 1'b0;

    // R4/R6: rising sweep
    for (int i = 0; i < 64; i++) begin
      set_ctrl(i, 8'h18);
      src[i] = 1'b1;
      @(negedge clk);
      chk("R4 irq not yet", 32'(irq), 0);
      @(negedge clk);
      chk("R4 rise irq", 32'(irq), 1);
      chk("R4 rise idx", 32'(idx), 32'(i));
      src[i] = 1'b0;
      reg_write(i < 32 ? 8'h80 : 8'h84, 32'h0, 4'hF);
      reg_read(i < 32 ? 8'h80 : 8'h84, d);
      chk("R6 write0 keeps", d, 32'(1) << (i % 32));
      chk("R4 latched irq", 32'(irq), 1);
      reg_write(i < 32 ? 8'h80 : 8'h84, 32'(1) << (i % 32), 4'hF);
      reg_read(i < 32 ? 8'h80 : 8'h84, d);
      chk("R6 write1 clears", d, 0);
      chk("R6 irq after clear", 32'(irq), 0);
      set_ctrl(i, 8'h00);
    end

    // R5: falling sweep
    for (int i = 0; i < 64; i++) begin
      src[i] = 1'b1;
      set_ctrl(i, 8'h28);
      src[i] = 1'b0;
      repeat (2) @(negedge clk);
      chk("R5 fall irq", 32'(irq), 1);
      chk("R5 fall idx", 32'(idx), 32'(i));
      reg_write(i < 32 ? 8'h80 : 8'h84, 32'(1) << (i % 32), 4'hF);
      set_ctrl(i, 8'h00);
    end

    // R4: disabled edge source latches nothing
    set_ctrl(5, 8'h10);
    src[5] = 1'b1;
    @(negedge clk);
    src[5] = 1'b0;
    reg_read(8'h80, d); chk("R4 disabled no latch", d, 0);
    set_ctrl(5, 8'h18);
    repeat (2) @(negedge clk);
    chk("R4 disabled no irq", 32'(irq), 0);
    set_ctrl(5, 8'h00);

    // R11: reserved mode
    set_ctrl(9, 8'h38);
    src[9] = 1'b1; repeat (2) @(negedge clk);
    src[9] = 1'b0; repeat (2) @(negedge clk);
    chk("R11 rsvd quiet", 32'(irq), 0);
    set_ctrl(9, 8'h00);

    // R7/R8: three contenders
    set_ctrl(3, 8'h08); set_ctrl(10, 8'h08); set_ctrl(40, 8'h08);
    src[3] = 1'b1; src[10] = 1'b1; src[40] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 fixed winner", 32'(idx), 3);
    end
    reg_write(8'h20, 32'h40, 4'h1);
    begin
      int prev;
      prev = int'(idx);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk("R8 rotate order", 32'(idx), 32'(next_of(prev)));
        prev = int'(idx);
      end
    end
    src = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle after rotate", 32'(irq), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule